// File: doc/BRIEF.md
# Unrecoverable Error Aggregator

This block collects sticky fault flags from up to 48 internal units into two status words: a low word with 32 flags and a high word with 16 flags. Each flag has a mask bit. Any flag that is set while its mask bit is clear is an unmasked fault. An unmasked fault raises a level interrupt toward the host and a second, identical one toward the management controller. In the same cycle it takes every unit offline by clearing all of the online-enable bits.

Software reaches the block through a 32-bit register port that is addressed by dword index. It clears a flag by writing a one to that flag's bit. It sets mask bits to silence units it does not care about. Once the fault is dealt with, it brings units back online by writing ones to the online-control words. The block does not restore the units by itself.

Top module: `ue_aggregator`

## Requirements
- R1: After reset, all status and mask bits read zero, both online words read all ones on their implemented bits, and both interrupt outputs are low.
- R2: A one-cycle pulse on an error input bit sets the matching status bit, and the bit stays set after the pulse ends. Low inputs 0–31 map to bits 0–31 at dword index 40. High inputs 0–15 map to bits 0–15 at index 41.
- R3: Writing a one to a status bit clears it. Writing a zero to a status bit leaves it unchanged.
- R4: If an error pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R5: A mask bit of one (low mask at index 42, high mask at index 43) stops its status bit from raising the interrupt and from forcing units offline. Clearing the mask bit later lets the pending flag take effect.
- R6: Both interrupt outputs are levels. Each one goes high one clock after any unmasked status bit exists, and goes low one clock after none is left.
- R7: An unmasked fault clears every bit of both online words (index 44 holds 32 units, index 45 holds 16). This happens on the same clock edge that the interrupt rises.
- R8: Online bits keep their value until software writes them. Writes of one bring units back, but while an unmasked fault is pending the forced offline state overrides the write.
- R9: Bits 16–31 of indices 41, 43 and 45 read zero and ignore writes. Any index outside 40–45 reads zero, and writes to such an index change no state.
- R10: Reads return the addressed register combinationally in the same cycle that the index is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_idx_i | input | 12 | Dword index of the register access |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_idx_i |
| err_lo_i | input | 32 | Error pulses from units 0–31 |
| err_hi_i | input | 16 | Error pulses from units 32–47 |
| host_irq_o | output | 1 | Unrecoverable-error interrupt to the host |
| mgmt_irq_o | output | 1 | Unrecoverable-error interrupt to the management controller |
| online_lo_o | output | 32 | Online enables for units 0–31 |
| online_hi_o | output | 16 | Online enables for units 32–47 |

## Verification
Two things can land on the same status bit in one cycle: a hardware error pulse and a software write-one-to-clear. The bench provokes this by driving both in the same clock for the same bit. It then expects the bit to read back as one and the interrupt to be high. A second coincidence is a software write of ones to the online words while an unmasked fault is still pending. The bench expects those words to read back as zero. It also expects them to change only after the fault is cleared and the write is repeated.

// File: rtl/ue_agg_pkg.sv
package ue_agg_pkg;
  localparam int IDX_W = 12;
  localparam int DW    = 32;
  localparam int LO_W  = 32;
  localparam int HI_W  = 16;

  typedef enum logic [IDX_W-1:0] {
    IDX_STAT_LO = 12'd40,
    IDX_STAT_HI = 12'd41,
    IDX_MASK_LO = 12'd42,
    IDX_MASK_HI = 12'd43,
    IDX_ONL_LO  = 12'd44,
    IDX_ONL_HI  = 12'd45
  } ue_idx_e;
endpackage

// File: rtl/ue_flag_word.sv
module ue_flag_word #(
  parameter int N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  input  logic         mask_we_i,
  input  logic [N-1:0] mask_wdata_i,
  output logic [N-1:0] status_o,
  output logic [N-1:0] mask_o,
  output logic         pend_o
);
  logic [N-1:0] status_q, mask_q;

  // set has priority over clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      mask_q   <= '0;
    end else begin
      status_q <= (status_q & ~clr_i) | set_i;
      if (mask_we_i) mask_q <= mask_wdata_i;
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign pend_o   = |(status_q & ~mask_q);

  AST_STICKY_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((~status_q & $past(status_q) & ~$past(clr_i)) == '0)); // R3
  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(set_i) & ~status_q) == '0)); // R4
endmodule

// File: rtl/ue_online_word.sv
module ue_online_word #(
  parameter int N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         we_i,
  input  logic [N-1:0] wdata_i,
  input  logic         force_off_i,
  output logic [N-1:0] online_o
);
  logic [N-1:0] online_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          online_q <= '1;
    else if (force_off_i) online_q <= '0;
    else if (we_i)        online_q <= wdata_i;
  end

  assign online_o = online_q;

  AST_FORCED_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_off_i |=> (online_q == '0)); // R7
  AST_HOLD_ONLINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!force_off_i && !we_i) |=> $stable(online_q)); // R8
endmodule

// File: rtl/ue_aggregator.sv
module ue_aggregator
  import ue_agg_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] reg_idx_i,
  input  logic             reg_we_i,
  input  logic [DW-1:0]    reg_wdata_i,
  output logic [DW-1:0]    reg_rdata_o,
  input  logic [LO_W-1:0]  err_lo_i,
  input  logic [HI_W-1:0]  err_hi_i,
  output logic             host_irq_o,
  output logic             mgmt_irq_o,
  output logic [LO_W-1:0]  online_lo_o,
  output logic [HI_W-1:0]  online_hi_o
);
  localparam int PAD_HI = DW - HI_W;

  logic [LO_W-1:0] stat_lo, mask_lo;
  logic [HI_W-1:0] stat_hi, mask_hi;
  logic            pend_lo, pend_hi, any_ue, irq_q;

  logic wr_stat_lo, wr_stat_hi, wr_mask_lo, wr_mask_hi, wr_onl_lo, wr_onl_hi;
  assign wr_stat_lo = reg_we_i && (reg_idx_i == IDX_STAT_LO);
  assign wr_stat_hi = reg_we_i && (reg_idx_i == IDX_STAT_HI);
  assign wr_mask_lo = reg_we_i && (reg_idx_i == IDX_MASK_LO);
  assign wr_mask_hi = reg_we_i && (reg_idx_i == IDX_MASK_HI);
  assign wr_onl_lo  = reg_we_i && (reg_idx_i == IDX_ONL_LO);
  assign wr_onl_hi  = reg_we_i && (reg_idx_i == IDX_ONL_HI);

  ue_flag_word #(.N(LO_W)) u_flag_lo (
    .clk_i, .rst_ni,
    .set_i       (err_lo_i),
    .clr_i       (wr_stat_lo ? reg_wdata_i[LO_W-1:0] : '0),
    .mask_we_i   (wr_mask_lo),
    .mask_wdata_i(reg_wdata_i[LO_W-1:0]),
    .status_o    (stat_lo),
    .mask_o      (mask_lo),
    .pend_o      (pend_lo)
  );

  ue_flag_word #(.N(HI_W)) u_flag_hi (
    .clk_i, .rst_ni,
    .set_i       (err_hi_i),
    .clr_i       (wr_stat_hi ? reg_wdata_i[HI_W-1:0] : '0),
    .mask_we_i   (wr_mask_hi),
    .mask_wdata_i(reg_wdata_i[HI_W-1:0]),
    .status_o    (stat_hi),
    .mask_o      (mask_hi),
    .pend_o      (pend_hi)
  );

  assign any_ue = pend_lo | pend_hi;

  ue_online_word #(.N(LO_W)) u_onl_lo (
    .clk_i, .rst_ni,
    .we_i       (wr_onl_lo),
    .wdata_i    (reg_wdata_i[LO_W-1:0]),
    .force_off_i(any_ue),
    .online_o   (online_lo_o)
  );

  ue_online_word #(.N(HI_W)) u_onl_hi (
    .clk_i, .rst_ni,
    .we_i       (wr_onl_hi),
    .wdata_i    (reg_wdata_i[HI_W-1:0]),
    .force_off_i(any_ue),
    .online_o   (online_hi_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= any_ue;
  end

  assign host_irq_o = irq_q;
  assign mgmt_irq_o = irq_q;

  always_comb begin
    unique case (reg_idx_i)
      IDX_STAT_LO: reg_rdata_o = stat_lo;
      IDX_STAT_HI: reg_rdata_o = {{PAD_HI{1'b0}}, stat_hi};
      IDX_MASK_LO: reg_rdata_o = mask_lo;
      IDX_MASK_HI: reg_rdata_o = {{PAD_HI{1'b0}}, mask_hi};
      IDX_ONL_LO:  reg_rdata_o = online_lo_o;
      IDX_ONL_HI:  reg_rdata_o = {{PAD_HI{1'b0}}, online_hi_o};
      default:     reg_rdata_o = '0;
    endcase
  end

  AST_IRQ_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_ue |=> host_irq_o && mgmt_irq_o); // R6
  AST_IRQ_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_ue |=> !host_irq_o && !mgmt_irq_o); // R6
  AST_IRQ_OFFLINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_irq_o |-> (online_lo_o == '0) && (online_hi_o == '0)); // R7
  AST_MASKED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (((stat_lo & ~mask_lo) == '0) && ((stat_hi & ~mask_hi) == '0)) |=> !host_irq_o); // R5
  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_idx_i == IDX_STAT_HI || reg_idx_i == IDX_MASK_HI || reg_idx_i == IDX_ONL_HI)
      |-> (reg_rdata_o[DW-1:HI_W] == '0)); // R9
endmodule

// File: tb/ue_aggregator_tb.sv
module ue_aggregator_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] reg_idx = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [31:0] err_lo = '0;
  logic [15:0] err_hi = '0;
  logic        host_irq, mgmt_irq;
  logic [31:0] online_lo;
  logic [15:0] online_hi;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ue_aggregator dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_idx_i(reg_idx), .reg_we_i(reg_we), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata),
    .err_lo_i(err_lo), .err_hi_i(err_hi),
    .host_irq_o(host_irq), .mgmt_irq_o(mgmt_irq),
    .online_lo_o(online_lo), .online_hi_o(online_hi)
  );

  // scoreboard: kind 0=rdata 1=host irq 2=mgmt irq 3=online lo 4=online hi
  int          kind_q[$];
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always @(negedge clk) begin
    while (kind_q.size() > 0) begin
      int          k;
      logic [31:0] e, a;
      string       t;
      k = kind_q.pop_front();
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      case (k)
        0: a = reg_rdata;
        1: a = {31'b0, host_irq};
        2: a = {31'b0, mgmt_irq};
        3: a = online_lo;
        default: a = {16'b0, online_hi};
      endcase
      checks++;
      if (a !== e) begin
        failures++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", t, k, a, e);
      end
    end
  end

  task automatic expect_rd(input logic [11:0] idx, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    reg_idx = idx;
    kind_q.push_back(0); exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); #1;
  endtask

  task automatic expect_port(input int k, input logic [31:0] e, input string t);
    @(posedge clk); #1;
    kind_q.push_back(k); exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); #1;
  endtask

  task automatic expect_irq(input bit v, input string t);
    expect_port(1, {31'b0, v}, t);
    expect_port(2, {31'b0, v}, t);
  endtask

  task automatic wr(input logic [11:0] idx, input logic [31:0] d);
    @(posedge clk); #1;
    reg_idx = idx; reg_wdata = d; reg_we = 1'b1;
    @(posedge clk); #1;
    reg_we = 1'b0;
  endtask

  task automatic pulse(input logic [31:0] lo, input logic [15:0] hi);
    @(posedge clk); #1;
    err_lo = lo; err_hi = hi;
    @(posedge clk); #1;
    err_lo = '0; err_hi = '0;
  endtask

  task automatic collide(input logic [31:0] clr_lo, input logic [31:0] set_lo);
    @(posedge clk); #1;
    reg_idx = 12'd40; reg_wdata = clr_lo; reg_we = 1'b1; err_lo = set_lo;
    @(posedge clk); #1;
    reg_we = 1'b0; err_lo = '0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 / R10 reset values through the map
    expect_rd(12'd40, 32'h0, "R1 stat lo");
    expect_rd(12'd41, 32'h0, "R1 stat hi");
    expect_rd(12'd42, 32'h0, "R1 mask lo");
    expect_rd(12'd43, 32'h0, "R1 mask hi");
    expect_rd(12'd44, 32'hFFFF_FFFF, "R1 R10 online lo");
    expect_rd(12'd45, 32'h0000_FFFF, "R1 R10 online hi");
    expect_irq(1'b0, "R1 irq");

    // R2 sticky set, R6 irq, R7 offline
    pulse(32'h0000_0020, 16'h0);
    expect_rd(12'd40, 32'h0000_0020, "R2 sticky lo");
    expect_irq(1'b1, "R6 irq high");
    expect_port(3, 32'h0, "R7 online lo off");
    expect_port(4, 32'h0, "R7 online hi off");

    // R3 write zero keeps, write one clears
    wr(12'd40, 32'h0);
    expect_rd(12'd40, 32'h0000_0020, "R3 w0 keeps");
    wr(12'd40, 32'h0000_0020);
    expect_rd(12'd40, 32'h0, "R3 w1 clears");
    expect_irq(1'b0, "R6 irq low");
    expect_rd(12'd44, 32'h0, "R8 no auto restore");

    // R8 restore, R9 reserved ignored
    wr(12'd44, 32'hFFFF_FFFF);
    wr(12'd45, 32'hFFFF_FFFF);
    expect_rd(12'd44, 32'hFFFF_FFFF, "R8 restore lo");
    expect_rd(12'd45, 32'h0000_FFFF, "R9 online hi rsvd");

    // R5 mask
    wr(12'd43, 32'hFFFF_0001);
    expect_rd(12'd43, 32'h0000_0001, "R9 mask hi rsvd");
    pulse(32'h0, 16'h0001);
    expect_rd(12'd41, 32'h0000_0001, "R2 sticky hi");
    expect_irq(1'b0, "R5 masked no irq");
    expect_port(4, 32'h0000_FFFF, "R5 masked stays online");
    wr(12'd43, 32'h0);
    expect_irq(1'b1, "R5 unmask irq");
    expect_port(3, 32'h0, "R5 R7 unmask offline");

    // R8 override while pending
    wr(12'd44, 32'hFFFF_FFFF);
    expect_rd(12'd44, 32'h0, "R8 override");
    wr(12'd41, 32'h0000_0001);
    expect_irq(1'b0, "R3 hi clear irq low");
    wr(12'd44, 32'hFFFF_FFFF);
    wr(12'd45, 32'h0000_FFFF);
    expect_port(3, 32'hFFFF_FFFF, "R8 online lo back");

    // R4 collision
    collide(32'h8000_0000, 32'h8000_0000);
    expect_rd(12'd40, 32'h8000_0000, "R4 set wins");
    expect_irq(1'b1, "R4 irq after collide");
    wr(12'd40, 32'h8000_0000);
    expect_rd(12'd40, 32'h0, "R3 clear after collide");

    // R9 unmapped
    wr(12'd50, 32'hFFFF_FFFF);
    expect_rd(12'd46, 32'h0, "R9 unmapped 46");
    expect_rd(12'd0, 32'h0, "R9 unmapped 0");
    expect_rd(12'd40, 32'h0, "R9 stray write no effect");
    expect_rd(12'd42, 32'h0, "R9 stray write mask");

    repeat (2) @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule